// File: doc/BRIEF.md
# Coprocessor Result Mailbox

This block holds the answer a lookup coprocessor returns to a network processor in two 64-bit result registers. When a command finishes, a one-cycle completion strobe brings in the operation class, the processor and context tags of the command, the raw search-engine word, the attached SRAM data and the hit status. The block packs these into the two registers according to the operation class and sets a done flag.

The host reads either register through a combinational read port. A read strobe aimed at register 0 produces a clear pulse and drops the done flag on the next clock edge. This is the handshake that frees the command descriptor for the next command. A configuration input selects whether a search hit also shows up as bit 63 of register 1.

The done flag is kept by a two-state machine. State EMPTY means no unread result and READY means a result is waiting. There are three transitions. FILL goes from EMPTY to READY on a completion. REFILL goes from READY to READY on a completion, whether or not register 0 is read in the same cycle. DRAIN goes from READY to EMPTY on a register 0 read with no completion in that cycle.

Top module: `res_mbox`

## Requirements
- R1: After reset both registers read as zero and the done flag (register 0 bit 0) is 0.
- R2: A completion strobe sets the done flag from the next cycle on. It also writes the processor tag to register 0 bits [20:16] and the context tag to bits [12:8].
- R3: A read strobe with host_addr=0 raises rd_clr in the same cycle. Without a completion in that cycle, done reads 0 from the next cycle on.
- R4: A read strobe with host_addr=1 leaves the done flag unchanged.
- R5: For an engine-word read (cmp_op=0), word bits [3:0] go to register 0 bits [7:4] and word bits [67:4] go to register 1.
- R6: For an SRAM read (cmp_op=1), register 1 takes the 64-bit SRAM data and register 0 bits [7:4] are zero.
- R7: For a write-type command (cmp_op=2), register 0 holds only the tags and done, and register 1 keeps its previous contents.
- R8: For a search hit (cmp_op=3, cmp_hit=1) with cfg_hit_in_data=0, register 0 bit 1 is 1 and register 1 equals the SRAM data.
- R9: For a search hit with cfg_hit_in_data=1, register 1 bit 63 is 1 and bits [62:0] are SRAM data bits [62:0].
- R10: For a search miss, register 0 bit 1 is 0 and register 1 is all zero, whatever cfg_hit_in_data is.
- R11: A completion and a register 0 read in the same cycle leave done set, and the registers hold the new result.
- R12: Every register 0 bit not named above reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion strobe, one cycle |
| cmp_op | input | 2 | Operation class: 0 engine read, 1 SRAM read, 2 write-type, 3 search |
| cmp_proc_id | input | 5 | Processor tag of the finished command |
| cmp_ctx_id | input | 5 | Context tag of the finished command |
| cmp_eng_word | input | 68 | Word read from the search engine |
| cmp_sram_data | input | 64 | Data from the attached SRAM |
| cmp_hit | input | 1 | Search hit status |
| cfg_hit_in_data | input | 1 | Put the search hit flag in register 1 bit 63 |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Register select: 0 or 1 |
| host_rdata | output | 64 | Selected register, combinational |
| rd_clr | output | 1 | Clear pulse on a register 0 read |

## Verification
The assertions watch every cycle for the following. A completion must set done. A register 0 read without a completion must drop it. A register 1 read must leave it alone. A write-type completion must leave register 1 untouched. A search miss must zero register 1, and a flagged hit must set its top bit. Only the bench scenarios can show the exact bit placement in register 0 for each operation class, the 64-bit contents of each packing, the reset values, and the collision case where a read and a completion land together.

// File: rtl/res_mbox_pkg.sv
package res_mbox_pkg;
    typedef enum logic [1:0] {
        OP_ENG_RD  = 2'd0,
        OP_SRAM_RD = 2'd1,
        OP_WRITE   = 2'd2,
        OP_SEARCH  = 2'd3
    } op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_READY = 1'b1
    } mbox_st_e;

    localparam int DONE_BIT = 0;
    localparam int HIT_BIT  = 1;
    localparam int ATTR_LSB = 4;
    localparam int CTX_LSB  = 8;
    localparam int PROC_LSB = 16;
endpackage

// File: rtl/res_mbox_pack.sv
module res_mbox_pack
    import res_mbox_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 5,
    parameter int ATTR_W = 4,
    localparam int ENG_W = DATA_W + ATTR_W
) (
    input  op_e               op,
    input  logic [TAG_W-1:0]  proc_id,
    input  logic [TAG_W-1:0]  ctx_id,
    input  logic [ENG_W-1:0]  eng_word,
    input  logic [DATA_W-1:0] sram_data,
    input  logic              hit,
    input  logic              hit_in_data,
    input  logic [DATA_W-1:0] r1_cur,
    output logic [DATA_W-1:0] r0_nxt,
    output logic [DATA_W-1:0] r1_nxt
);
    always_comb begin
        r0_nxt = '0;
        r0_nxt[PROC_LSB +: TAG_W] = proc_id;
        r0_nxt[CTX_LSB  +: TAG_W] = ctx_id;
        r1_nxt = r1_cur;
        unique case (op)
            OP_ENG_RD: begin
                r0_nxt[ATTR_LSB +: ATTR_W] = eng_word[ATTR_W-1:0];
                r1_nxt = eng_word[ENG_W-1:ATTR_W];
            end
            OP_SRAM_RD: begin
                r1_nxt = sram_data;
            end
            OP_WRITE: begin
                r1_nxt = r1_cur;
            end
            OP_SEARCH: begin
                r0_nxt[HIT_BIT] = hit;
                if (!hit) begin
                    r1_nxt = '0;
                end else if (hit_in_data) begin
                    r1_nxt = {1'b1, sram_data[DATA_W-2:0]};
                end else begin
                    r1_nxt = sram_data;
                end
            end
            default: r1_nxt = r1_cur;
        endcase
    end
endmodule

// File: rtl/res_mbox_fsm.sv
module res_mbox_fsm
    import res_mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fill,
    input  logic drain,
    output logic done
);
    mbox_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (fill) st_d = ST_READY;
            ST_READY: begin
                if (fill)       st_d = ST_READY;
                else if (drain) st_d = ST_EMPTY;
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        done = (st_q == ST_READY);
    end
endmodule

// File: rtl/res_mbox.sv
module res_mbox
    import res_mbox_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 5,
    parameter int ATTR_W = 4,
    localparam int ENG_W = DATA_W + ATTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_op,
    input  logic [TAG_W-1:0]  cmp_proc_id,
    input  logic [TAG_W-1:0]  cmp_ctx_id,
    input  logic [ENG_W-1:0]  cmp_eng_word,
    input  logic [DATA_W-1:0] cmp_sram_data,
    input  logic              cmp_hit,
    input  logic              cfg_hit_in_data,
    input  logic              host_rd,
    input  logic              host_addr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rd_clr
);
    logic [DATA_W-1:0] r0_q, r1_q, r0_nxt, r1_nxt;
    logic              done;

    res_mbox_pack #(.DATA_W(DATA_W), .TAG_W(TAG_W), .ATTR_W(ATTR_W)) pack_i (
        .op          (op_e'(cmp_op)),
        .proc_id     (cmp_proc_id),
        .ctx_id      (cmp_ctx_id),
        .eng_word    (cmp_eng_word),
        .sram_data   (cmp_sram_data),
        .hit         (cmp_hit),
        .hit_in_data (cfg_hit_in_data),
        .r1_cur      (r1_q),
        .r0_nxt      (r0_nxt),
        .r1_nxt      (r1_nxt)
    );

    res_mbox_fsm fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fill  (cmp_valid),
        .drain (rd_clr),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r0_q <= '0;
            r1_q <= '0;
        end else if (cmp_valid) begin
            r0_q <= r0_nxt;
            r1_q <= r1_nxt;
        end
    end

    always_comb begin
        rd_clr = host_rd && !host_addr;
        if (host_addr) begin
            host_rdata = r1_q;
        end else begin
            host_rdata = r0_q;
            host_rdata[DONE_BIT] = done;
        end
    end

    assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> done);
    assert_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !cmp_valid) |=> !done);
    assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr && !cmp_valid) |=> (done == $past(done)));
    assert_write_r1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_op == OP_WRITE) |=> $stable(r1_q));
    assert_hit_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_op == OP_SEARCH && cmp_hit && cfg_hit_in_data) |=> r1_q[DATA_W-1]);
    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_op == OP_SEARCH && !cmp_hit) |=> (r1_q == '0));
endmodule

// File: tb/res_mbox_tb_top.sv
module res_mbox_tb_top;
    localparam int NV = 7;
    localparam int VW = 2 + 5 + 5 + 68 + 64 + 1 + 1;

    // {op, proc, ctx, eng_word, sram, hit, cfg}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 5'd3,  5'd17, 68'hA_1234_5678_9ABC_DEF5, 64'h1111_2222_3333_4444, 1'b0, 1'b0},
        {2'd1, 5'd31, 5'd0,  68'hF_FFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, 1'b0},
        {2'd2, 5'd7,  5'd9,  68'h5_5555_5555_5555_5555, 64'h0000_0000_0000_0077, 1'b1, 1'b1},
        {2'd3, 5'd1,  5'd30, 68'h0_0000_0000_0000_000F, 64'h7000_0000_0000_0001, 1'b1, 1'b0},
        {2'd3, 5'd16, 5'd1,  68'h0_0000_0000_0000_000F, 64'h7000_0000_0000_0001, 1'b1, 1'b1},
        {2'd3, 5'd21, 5'd21, 68'hC_0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1},
        {2'd3, 5'd10, 5'd5,  68'h0_0000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_op = '0;
    logic [4:0]  cmp_proc_id = '0;
    logic [4:0]  cmp_ctx_id = '0;
    logic [67:0] cmp_eng_word = '0;
    logic [63:0] cmp_sram_data = '0;
    logic        cmp_hit = 1'b0;
    logic        cfg_hit_in_data = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_addr = 1'b0;
    logic [63:0] host_rdata;
    logic        rd_clr;

    int n_tests = 0;
    int n_fail = 0;
    logic [63:0] exp_r0, exp_r1;

    always #5 clk = ~clk;

    res_mbox dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
        .cmp_proc_id(cmp_proc_id), .cmp_ctx_id(cmp_ctx_id), .cmp_eng_word(cmp_eng_word),
        .cmp_sram_data(cmp_sram_data), .cmp_hit(cmp_hit), .cfg_hit_in_data(cfg_hit_in_data),
        .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata), .rd_clr(rd_clr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected register contents from the requirements (done bit set).
    task automatic model(input logic [VW-1:0] v);
        logic [1:0] op; logic [4:0] p, c; logic [67:0] w; logic [63:0] s; logic h, f;
        {op, p, c, w, s, h, f} = v;
        exp_r0 = '0;
        exp_r0[0] = 1'b1;
        exp_r0[20:16] = p;
        exp_r0[12:8] = c;
        case (op)
            2'd0: begin exp_r0[7:4] = w[3:0]; exp_r1 = w[67:4]; end
            2'd1: exp_r1 = s;
            2'd2: exp_r1 = exp_r1;
            default: begin
                exp_r0[1] = h;
                exp_r1 = !h ? 64'd0 : (f ? {1'b1, s[62:0]} : s);
            end
        endcase
    endtask

    task automatic drive(input logic [VW-1:0] v);
        {cmp_op, cmp_proc_id, cmp_ctx_id, cmp_eng_word, cmp_sram_data, cmp_hit, cfg_hit_in_data} = v;
        cmp_valid = 1'b1;
    endtask

    task automatic read_reg(input logic a, output logic [63:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        exp_r1 = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        read_reg(1'b0, d); chk("R1 reg0", d, 64'd0);
        read_reg(1'b1, d); chk("R1 reg1", d, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(1'b0, d); chk("R1 reg0 after release", d, 64'd0);

        // Table walk: R2 R5 R6 R7 R8 R9 R10 R12, then R3 clear handshake
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            model(VEC[i]);
            @(negedge clk);
            cmp_valid = 1'b0;
            read_reg(1'b0, d); chk($sformatf("R2/R5-R10/R12 reg0 vec%0d", i), d, exp_r0);
            read_reg(1'b1, d); chk($sformatf("R5-R10 reg1 vec%0d", i), d, exp_r1);
            host_addr = 1'b0; host_rd = 1'b1; #1;
            chk($sformatf("R3 pulse vec%0d", i), {63'd0, rd_clr}, 64'd1);
            @(negedge clk);
            host_rd = 1'b0;
            read_reg(1'b0, d); chk($sformatf("R3 done cleared vec%0d", i), {63'd0, d[0]}, 64'd0);
            chk($sformatf("R3 fields kept vec%0d", i), d, exp_r0 & ~64'd1);
        end

        // R4: reading register 1 leaves done set
        drive(VEC[0]); model(VEC[0]);
        @(negedge clk);
        cmp_valid = 1'b0;
        host_addr = 1'b1; host_rd = 1'b1; #1;
        chk("R4 no pulse", {63'd0, rd_clr}, 64'd0);
        @(negedge clk);
        host_rd = 1'b0;
        read_reg(1'b0, d); chk("R4 done kept", {63'd0, d[0]}, 64'd1);

        // R11: completion and register 0 read collide
        drive(VEC[4]); model(VEC[4]);
        host_addr = 1'b0; host_rd = 1'b1; #1;
        chk("R11 pulse", {63'd0, rd_clr}, 64'd1);
        @(negedge clk);
        cmp_valid = 1'b0; host_rd = 1'b0;
        read_reg(1'b0, d); chk("R11 reg0 new result done", d, exp_r0);
        read_reg(1'b1, d); chk("R11 reg1 new result", d, exp_r1);

        // R7: write-type after a search hit keeps that register 1
        drive(VEC[2]); model(VEC[2]);
        @(negedge clk);
        cmp_valid = 1'b0;
        read_reg(1'b1, d); chk("R7 reg1 retained", d, 64'hF000_0000_0000_0001);
        read_reg(1'b0, d); chk("R7 reg0 tags only", d, exp_r0);

        // R1: reset clears everything again
        rst_n = 1'b0;
        @(negedge clk);
        read_reg(1'b0, d); chk("R1 reg0 re-reset", d, 64'd0);
        read_reg(1'b1, d); chk("R1 reg1 re-reset", d, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule